// File: doc/BRIEF.md
# Receive FIFO with Trigger-Level Interrupt

This block buffers received characters between a serial deserializer and a host. Bytes arrive on a push strobe and leave through a first-word-fall-through read port: `rd_data` always shows the oldest stored byte, and a host read of the holding register pulses `pop`. The block reports the fill level as an 8-bit count, together with empty, full and data-ready flags. It also keeps a sticky overrun flag, which the host clears with a status read.

The receive-data-available interrupt is a level signal. It is a plain comparison of the fill level against a programmable threshold. It needs no acknowledge: it drops as soon as reads bring the level under the threshold. With `fifo_en` low the store shrinks to a single holding byte, and the interrupt then means that one byte is waiting. Any change of `fifo_en` discards the stored data.

Top module: `rx_trig_fifo`

## Requirements
- R1: With `fifo_en`=1 the block stores up to 128 bytes and returns them in arrival order; `full` is 1 exactly when 128 bytes are held.
- R2: `rda_irq` is 0 whenever `rx_irq_en` is 0, whatever the level.
- R3: With both enables at 1, `rda_irq` is 1 in every cycle in which `level` is at or above `trig_level`.
- R4: `rda_irq` returns to 0 in the same cycle that `level` falls below the threshold, with no acknowledge.
- R5: `level` gives the stored byte count (0 to 128); `empty` is 1 when the count is 0, and `data_ready` is its inverse.
- R6: With `fifo_en`=0 the block holds at most one byte, `full` is 1 while that byte is present, `trig_level` is ignored, and `rda_irq` (when `rx_irq_en`=1) is 1 while the byte is present.
- R7: A push while full, with no pop in the same cycle, is dropped and sets `overrun`. `overrun` stays 1 until a cycle with `status_rd`=1, and a new drop in that same cycle keeps it set.
- R8: A push and a pop in the same cycle on a non-empty store leave `level` unchanged, including when full; the pushed byte joins the tail.
- R9: In FIFO mode a `trig_level` of 0 acts as 1.
- R10: In the first cycle after `fifo_en` changes value, the store is emptied, and any push or pop in that cycle is ignored. The reset state counts as `fifo_en`=0.
- R11: A pop while empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1: 128-byte FIFO, 0: single holding byte |
| rx_irq_en | input | 1 | Receive-data interrupt enable |
| trig_level | input | 8 | Interrupt threshold in bytes |
| push_valid | input | 1 | Byte from deserializer is valid |
| push_data | input | 8 | Received byte |
| pop | input | 1 | Host read of the head byte |
| rd_data | output | 8 | Oldest stored byte |
| status_rd | input | 1 | Host status read, clears overrun |
| level | output | 8 | Stored byte count |
| empty | output | 1 | No byte stored |
| full | output | 1 | Store at capacity |
| data_ready | output | 1 | At least one byte stored |
| overrun | output | 1 | Sticky dropped-byte flag |
| rda_irq | output | 1 | Receive-data-available interrupt |

## Verification
The hardest states to reach are those at full capacity: the overrun drop and the combined push-and-pop while 128 bytes are held. The stimulus gets there by filling the FIFO with a known byte pattern while checking the interrupt on both sides of the threshold. It then pushes into the full store, pushes and pops together, and drains all 128 bytes, checking the order and watching the interrupt fall below the threshold. Mode changes are exercised with data present, so that the flush is visible.

// File: rtl/rx_trig_pkg.sv
package rx_trig_pkg;

    typedef enum logic {
        MODE_HOLD = 1'b0,
        MODE_FIFO = 1'b1
    } rx_mode_e;

endpackage

// File: rtl/rx_fifo_mem.sv
module rx_fifo_mem #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = store_q[rd_addr];

endmodule

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl
    import rx_trig_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              push_valid,
    input  logic              pop,
    input  logic              status_rd,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty,
    output logic              overrun
);

    typedef struct packed {
        logic [ADDR_W-1:0] wr;
        logic [ADDR_W-1:0] rd;
        logic [CNT_W-1:0]  cnt;
        logic              ovr;
        rx_mode_e          mode;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    rx_mode_e         mode_now;
    logic [CNT_W-1:0] cap;
    logic             flush, at_cap, do_pop, do_push, drop;

    function automatic logic [ADDR_W-1:0] adv(input logic [ADDR_W-1:0] p);
        return (p == ADDR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        mode_now = fifo_en ? MODE_FIFO : MODE_HOLD;
        cap      = (mode_now == MODE_FIFO) ? CNT_W'(DEPTH) : CNT_W'(1);
        flush    = (mode_now != st_q.mode);
        at_cap   = (st_q.cnt >= cap);
        do_pop   = pop && (st_q.cnt != '0) && !flush;
        do_push  = push_valid && !flush && (!at_cap || do_pop);
        drop     = push_valid && !flush && !do_push;

        st_d      = st_q;
        st_d.mode = mode_now;
        if (flush) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) st_d.wr = adv(st_q.wr);
            if (do_pop)  st_d.rd = adv(st_q.rd);
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
        if (drop) begin
            st_d.ovr = 1'b1;
        end else if (status_rd) begin
            st_d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wr: '0, rd: '0, cnt: '0, ovr: 1'b0, mode: MODE_HOLD};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en   = do_push;
    assign wr_addr = st_q.wr;
    assign rd_addr = st_q.rd;
    assign count   = st_q.cnt;
    assign full    = at_cap;
    assign empty   = (st_q.cnt == '0);
    assign overrun = st_q.ovr;

endmodule

// File: rtl/rx_trig_cmp.sv
module rx_trig_cmp #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] trig_level,
    input  logic             fifo_en,
    input  logic             rx_irq_en,
    output logic             irq
);

    logic [CNT_W-1:0] thr;

    always_comb begin
        if (!fifo_en || (trig_level == '0)) begin
            thr = CNT_W'(1);
        end else begin
            thr = trig_level;
        end
        irq = rx_irq_en && (count >= thr);
    end

endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              rx_irq_en,
    input  logic [CNT_W-1:0]  trig_level,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    input  logic              status_rd,
    output logic [CNT_W-1:0]  level,
    output logic              empty,
    output logic              full,
    output logic              data_ready,
    output logic              overrun,
    output logic              rda_irq
);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [CNT_W-1:0]  count;
    logic              empty_i;

    rx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (fifo_en),
        .push_valid(push_valid),
        .pop       (pop),
        .status_rd (status_rd),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .count     (count),
        .full      (full),
        .empty     (empty_i),
        .overrun   (overrun)
    );

    rx_fifo_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(push_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    rx_trig_cmp #(.CNT_W(CNT_W)) u_cmp (
        .count     (count),
        .trig_level(trig_level),
        .fifo_en   (fifo_en),
        .rx_irq_en (rx_irq_en),
        .irq       (rda_irq)
    );

    assign level      = count;
    assign empty      = empty_i;
    assign data_ready = !empty_i;

endmodule

// File: rtl/rx_trig_fifo_chk.sv
module rx_trig_fifo_chk #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_en,
    input logic              rx_irq_en,
    input logic [CNT_W-1:0]  trig_level,
    input logic              push_valid,
    input logic [DATA_W-1:0] push_data,
    input logic              pop,
    input logic [DATA_W-1:0] rd_data,
    input logic              status_rd,
    input logic [CNT_W-1:0]  level,
    input logic              empty,
    input logic              full,
    input logic              data_ready,
    input logic              overrun,
    input logic              rda_irq
);

    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));

    p_irq_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_irq_en |-> !rda_irq);

    p_irq_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rda_irq |-> !empty);

    p_hold_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !empty) |-> full);

    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !status_rd) |=> overrun);

    p_pushpop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && pop && !empty) |=> ((level == $past(level)) || (level == '0)));

    p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push_valid) |=> empty);

endmodule

bind rx_trig_fifo rx_trig_fifo_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_rx_trig_fifo.sv
module tb_rx_trig_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic       rx_irq_en = 1'b0;
    logic [7:0] trig_level = 8'd0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = 8'd0;
    logic       pop = 1'b0;
    logic       status_rd = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] level;
    logic       empty, full, data_ready, overrun, rda_irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rx_trig_fifo dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_irq_en(rx_irq_en),
        .trig_level(trig_level), .push_valid(push_valid), .push_data(push_data),
        .pop(pop), .rd_data(rd_data), .status_rd(status_rd), .level(level),
        .empty(empty), .full(full), .data_ready(data_ready), .overrun(overrun),
        .rda_irq(rda_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive for one clock edge; returns at the following falling edge.
    task automatic step(input logic pv, input logic [7:0] pd, input logic pp, input logic sr);
        push_valid = pv; push_data = pd; pop = pp; status_rd = sr;
        @(posedge clk);
        @(negedge clk);
        push_valid = 1'b0; pop = 1'b0; status_rd = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 3 + 1) & 8'hff);
    endfunction

    task automatic t_reset();
        check("R5 reset level", level, 0);
        check("R5 reset empty", empty, 1);
        check("R5 reset data_ready", data_ready, 0);
        check("R1 reset full", full, 0);
        check("R7 reset overrun", overrun, 0);
        check("R2 reset irq", rda_irq, 0);
    endtask

    task automatic t_fill();
        fifo_en = 1'b1; rx_irq_en = 1'b1; trig_level = 8'd16;
        step(1'b1, 8'h99, 1'b0, 1'b0);   // mode-change cycle: push ignored
        check("R10 push ignored on mode change", level, 0);
        for (int i = 0; i < 128; i++) begin
            step(1'b1, pat(i), 1'b0, 1'b0);
            check("R5 level while filling", level, i + 1);
            if (i + 1 == 15) check("R3 irq below trigger", rda_irq, 0);
            if (i + 1 == 16) check("R3 irq at trigger", rda_irq, 1);
            if (i + 1 == 127) check("R1 not full at 127", full, 0);
        end
        check("R1 full at 128", full, 1);
        check("R3 irq at full", rda_irq, 1);
    endtask

    task automatic t_overrun();
        step(1'b1, 8'hEE, 1'b0, 1'b0);
        check("R7 level after drop", level, 128);
        check("R7 overrun set", overrun, 1);
        step(1'b0, 8'h00, 1'b0, 1'b0);
        check("R7 overrun sticky", overrun, 1);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        check("R7 overrun cleared", overrun, 0);
    endtask

    task automatic t_pushpop_full();
        check("R1 head byte", rd_data, pat(0));
        step(1'b1, 8'hA5, 1'b1, 1'b0);
        check("R8 level unchanged at full", level, 128);
        check("R7 no overrun on push+pop", overrun, 0);
    endtask

    task automatic t_drain();
        for (int k = 0; k < 128; k++) begin
            check("R1 drain order", rd_data, (k < 127) ? pat(k + 1) : 8'hA5);
            step(1'b0, 8'h00, 1'b1, 1'b0);
            if (level == 8'd16 || level == 8'd15) begin
                check("R4 irq follows level", rda_irq, (128 - k - 1) >= 16);
            end
        end
        check("R5 empty after drain", empty, 1);
        check("R5 data_ready after drain", data_ready, 0);
        check("R4 irq after drain", rda_irq, 0);
    endtask

    task automatic t_pop_empty();
        step(1'b0, 8'h00, 1'b1, 1'b0);
        check("R11 level after pop on empty", level, 0);
        check("R11 empty after pop on empty", empty, 1);
        step(1'b1, 8'h42, 1'b0, 1'b0);
        check("R11 pointers intact", rd_data, 8'h42);
        step(1'b0, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic t_enables();
        for (int i = 0; i < 20; i++) step(1'b1, 8'(i), 1'b0, 1'b0);
        rx_irq_en = 1'b0; #1;
        check("R2 irq masked", rda_irq, 0);
        rx_irq_en = 1'b1; #1;
        check("R3 irq unmasked", rda_irq, 1);
        trig_level = 8'd25; #1;
        check("R3 irq with higher trigger", rda_irq, 0);
        trig_level = 8'd0; #1;
        check("R9 trigger 0 with data", rda_irq, 1);
        trig_level = 8'd25;
        fifo_en = 1'b0;
        step(1'b0, 8'h00, 1'b0, 1'b0);
        check("R10 flush on mode change", level, 0);
    endtask

    task automatic t_hold();
        step(1'b1, 8'h3C, 1'b0, 1'b0);
        check("R6 hold level", level, 1);
        check("R6 hold full", full, 1);
        check("R6 hold irq ignores trigger", rda_irq, 1);
        rx_irq_en = 1'b0; #1;
        check("R2 hold irq masked", rda_irq, 0);
        rx_irq_en = 1'b1;
        step(1'b1, 8'h77, 1'b0, 1'b0);
        check("R7 hold drop keeps byte", rd_data, 8'h3C);
        check("R7 hold overrun", overrun, 1);
        step(1'b1, 8'h55, 1'b0, 1'b1);
        check("R7 drop wins over status read", overrun, 1);
        step(1'b1, 8'h81, 1'b1, 1'b1);
        check("R8 hold push+pop level", level, 1);
        check("R8 hold push+pop data", rd_data, 8'h81);
        check("R7 cleared in hold", overrun, 0);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        check("R6 hold emptied", level, 0);
        check("R6 hold irq clears", rda_irq, 0);
    endtask

    task automatic t_trig0();
        fifo_en = 1'b1; trig_level = 8'd0;
        step(1'b0, 8'h00, 1'b0, 1'b0);
        check("R9 empty irq", rda_irq, 0);
        step(1'b1, 8'h10, 1'b0, 1'b0);
        check("R9 trigger 0 acts as 1", rda_irq, 1);
        check("R6 fifo mode not full at 1", full, 0);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        check("R4 irq clears at 0", rda_irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_overrun();
        t_pushpop_full();
        t_drain();
        t_pop_empty();
        t_enables();
        t_hold();
        t_trig0();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule